// File: doc/BRIEF.md
# Line Adapter Interrupt Status Word

This block keeps the 16-bit status word of a character-oriented asynchronous line adapter and decides when the adapter asks the host processor for service. Upstream logic has already deserialized each received character and computed its parity, synchronization and longitudinal checks. Those results reach the block as flags that travel with the character. The block watches the character stream for two control codes: a data-link escape character and an end-of-transmission character. From them it tracks a transparent (binary) data mode. It also follows the data-set-ready line, the mode and busy levels, and an overrun pulse, and folds all of these into the word.

The word holds two kinds of bits. Request bits latch an event and drive the interrupt line until the host reads the word. Live bits mirror the adapter's current state and never request service. A host read strobe returns the word and clears the request bits and the summary indicator. An end-of-transmission character outside binary mode replaces all earlier request bits with device end alone. Bit n of the word is `stat_word[n]`.

Top module: `line_status_word`

## Requirements
- R1: After reset, `stat_word` is 0, and `irq` and `summary` are low.
- R2: A character accepted while `recv_mode` is high (`rx_valid` high) sets device end, bit 13, on the following clock edge.
- R3: On an accepted character that is not a control end-of-transmission, `err_vrc` or `err_sync` sets bit 4, `err_lrc` sets bit 3 and `err_nak` sets bit 6. Any of the four also sets data check, bit 14.
- R4: A pulse on `overrun` sets bit 2. A falling edge of `dsr` while `xmit_mode` or `recv_mode` is high sets bit 7. Neither event changes bit 13.
- R5: Two consecutive escape characters (`DS_CODE`) set bit 8 (binary mode). A single escape followed by any other character does not set it. In binary mode an escape pair counts as one literal character and keeps the mode, while an escape followed by any other character clears bit 8. Dropping `recv_mode` clears bit 8.
- R6: An `EOT_CODE` character outside binary mode clears every other request bit, sets bit 13 and sets `summary`. In binary mode that code is ordinary data and leaves `summary` unchanged.
- R7: Bit 10 follows `recv_mode` and bit 12 follows `busy`, one clock later. Neither bit ever raises `irq`.
- R8: `stat_rd` clears bits 2, 3, 4, 6, 7, 13 and 14 and the `summary` flag, and keeps bits 8, 10 and 12. An event in the same cycle as the read takes priority and is kept.
- R9: `irq` is high exactly while any of bits 2, 3, 4, 6, 7, 13 or 14 is set, and it changes on the same edge as the word.
- R10: A character presented while `recv_mode` is low changes no bit of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recv_mode | input | 1 | Adapter is in receive mode |
| xmit_mode | input | 1 | Adapter is in transmit mode |
| busy | input | 1 | A character is in progress for a command |
| dsr | input | 1 | Data set ready level |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_char | input | CHAR_W | Received character code |
| err_vrc | input | 1 | Character parity error |
| err_sync | input | 1 | Synchronization error |
| err_lrc | input | 1 | Block check error at end of block |
| err_nak | input | 1 | Negative response received |
| overrun | input | 1 | One-cycle overrun pulse |
| stat_rd | input | 1 | Host status read strobe |
| stat_word | output | 16 | Interrupt status word |
| summary | output | 1 | Summary status indicator |
| irq | output | 1 | Interrupt request to the host |

## Verification
The hardest states to reach are the binary-mode transitions. An escape character means different things depending on the one before it, and end-of-transmission is control or data depending on the mode already entered. The bench sweeps every ordered pair drawn from {escape, plain, end-of-transmission}, starting each pair from text mode. It then walks a long scripted run inside binary mode: a literal escape pair, an embedded end-of-transmission code, a read in the middle of the run, and an exit. It also sweeps all sixteen error-flag combinations and drives a read in the same cycle as a new character.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int WORD_W = 16;

  // Bit positions the host decodes.
  localparam int B_OVR = 2;
  localparam int B_EOB = 3;
  localparam int B_CHK = 4;
  localparam int B_NAK = 6;
  localparam int B_DSE = 7;
  localparam int B_BIN = 8;
  localparam int B_RCV = 10;
  localparam int B_BSY = 12;
  localparam int B_DEV = 13;
  localparam int B_DCK = 14;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t IRQ_MASK = (word_t'(1) << B_OVR) | (word_t'(1) << B_EOB) |
                               (word_t'(1) << B_CHK) | (word_t'(1) << B_NAK) |
                               (word_t'(1) << B_DSE) | (word_t'(1) << B_DEV) |
                               (word_t'(1) << B_DCK);

  typedef enum logic [1:0] {
    CS_TEXT    = 2'd0,
    CS_TEXT_DS = 2'd1,
    CS_BIN     = 2'd2,
    CS_BIN_DS  = 2'd3
  } cs_t;

  // Bits raised by the error flags of one received character.
  function automatic word_t err_bits(input logic vrc, input logic sync,
                                     input logic lrc, input logic nak);
    word_t w;
    w = '0;
    w[B_CHK] = vrc | sync;
    w[B_EOB] = lrc;
    w[B_NAK] = nak;
    w[B_DCK] = vrc | sync | lrc | nak;
    return w;
  endfunction

  // Next control state for one accepted character.
  function automatic cs_t cs_step(input cs_t cur, input logic is_ds);
    cs_t n;
    case (cur)
      CS_TEXT:    n = is_ds ? CS_TEXT_DS : CS_TEXT;
      CS_TEXT_DS: n = is_ds ? CS_BIN     : CS_TEXT;
      CS_BIN:     n = is_ds ? CS_BIN_DS  : CS_BIN;
      default:    n = is_ds ? CS_BIN     : CS_TEXT;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/lsw_ctl_detect.sv
module lsw_ctl_detect
  import lsw_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] DS_CODE  = 8'h10,
  parameter logic [CHAR_W-1:0] EOT_CODE = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recv_mode,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              ds_hit,
  output logic              eot_hit,
  output logic              bin_mode
);
  cs_t  cs_q;
  logic rx_take;
  logic in_bin;

  assign rx_take  = rx_valid & recv_mode;
  assign in_bin   = (cs_q == CS_BIN) || (cs_q == CS_BIN_DS);
  assign ds_hit   = rx_take && (rx_char == DS_CODE);
  assign eot_hit  = rx_take && (rx_char == EOT_CODE) && !in_bin;
  assign bin_mode = in_bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= CS_TEXT;
    end else if (!recv_mode) begin
      cs_q <= CS_TEXT;
    end else if (rx_take) begin
      cs_q <= cs_step(cs_q, ds_hit);
    end
  end
endmodule

// File: rtl/lsw_event_gen.sv
module lsw_event_gen
  import lsw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  recv_mode,
  input  logic  xmit_mode,
  input  logic  dsr,
  input  logic  rx_valid,
  input  logic  err_vrc,
  input  logic  err_sync,
  input  logic  err_lrc,
  input  logic  err_nak,
  input  logic  overrun,
  input  logic  eot_hit,
  output word_t set_bits,
  output logic  dse_event
);
  logic dsr_q;
  logic rx_take;

  assign rx_take   = rx_valid & recv_mode;
  assign dse_event = dsr_q & ~dsr & (xmit_mode | recv_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dsr_q <= 1'b0;
    else        dsr_q <= dsr;
  end

  always_comb begin
    set_bits = '0;
    set_bits[B_OVR] = overrun;
    set_bits[B_DSE] = dse_event;
    if (rx_take) begin
      set_bits[B_DEV] = 1'b1;
      if (!eot_hit) set_bits = set_bits | err_bits(err_vrc, err_sync, err_lrc, err_nak);
    end
  end
endmodule

// File: rtl/lsw_word_reg.sv
module lsw_word_reg
  import lsw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_bits,
  input  logic  eot_hit,
  input  logic  stat_rd,
  input  logic  bin_mode,
  input  logic  recv_mode,
  input  logic  busy,
  output word_t stat_word,
  output logic  summary,
  output logic  irq
);
  word_t pend_q;
  word_t pend_nxt;
  logic  sum_q;
  logic  sum_nxt;
  logic  irq_q;
  logic  recv_q;
  logic  busy_q;
  word_t live;

  always_comb begin
    pend_nxt = pend_q;
    if (stat_rd || eot_hit) pend_nxt = '0;
    pend_nxt = pend_nxt | (set_bits & IRQ_MASK);
    if (eot_hit)      sum_nxt = 1'b1;
    else if (stat_rd) sum_nxt = 1'b0;
    else              sum_nxt = sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      sum_q  <= 1'b0;
      irq_q  <= 1'b0;
      recv_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      sum_q  <= sum_nxt;
      irq_q  <= |pend_nxt;
      recv_q <= recv_mode;
      busy_q <= busy;
    end
  end

  always_comb begin
    live = '0;
    live[B_BIN] = bin_mode;
    live[B_RCV] = recv_q;
    live[B_BSY] = busy_q;
  end

  assign stat_word = pend_q | live;
  assign summary   = sum_q;
  assign irq       = irq_q;
endmodule

// File: rtl/line_status_word.sv
module line_status_word
  import lsw_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] DS_CODE  = 8'h10,
  parameter logic [CHAR_W-1:0] EOT_CODE = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recv_mode,
  input  logic              xmit_mode,
  input  logic              busy,
  input  logic              dsr,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              err_vrc,
  input  logic              err_sync,
  input  logic              err_lrc,
  input  logic              err_nak,
  input  logic              overrun,
  input  logic              stat_rd,
  output logic [15:0]       stat_word,
  output logic              summary,
  output logic              irq
);
  logic  ds_hit;
  logic  eot_hit;
  logic  bin_mode;
  logic  dse_event;
  word_t set_bits;

  lsw_ctl_detect #(.CHAR_W(CHAR_W), .DS_CODE(DS_CODE), .EOT_CODE(EOT_CODE)) i_ctl (
    .clk(clk), .rst_n(rst_n), .recv_mode(recv_mode), .rx_valid(rx_valid),
    .rx_char(rx_char), .ds_hit(ds_hit), .eot_hit(eot_hit), .bin_mode(bin_mode)
  );

  lsw_event_gen i_evt (
    .clk(clk), .rst_n(rst_n), .recv_mode(recv_mode), .xmit_mode(xmit_mode),
    .dsr(dsr), .rx_valid(rx_valid), .err_vrc(err_vrc), .err_sync(err_sync),
    .err_lrc(err_lrc), .err_nak(err_nak), .overrun(overrun), .eot_hit(eot_hit),
    .set_bits(set_bits), .dse_event(dse_event)
  );

  lsw_word_reg i_word (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .eot_hit(eot_hit),
    .stat_rd(stat_rd), .bin_mode(bin_mode), .recv_mode(recv_mode), .busy(busy),
    .stat_word(stat_word), .summary(summary), .irq(irq)
  );
endmodule

// File: rtl/lsw_checker.sv
module lsw_checker
  import lsw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        recv_mode,
  input logic        overrun,
  input logic        stat_rd,
  input logic        ds_hit,
  input logic        eot_hit,
  input logic        dse_event,
  input logic [15:0] stat_word,
  input logic        summary,
  input logic        irq
);
  localparam logic [15:0] DEV_ONLY = 16'h1 << B_DEV;
  localparam logic [15:0] OVR_BIT  = 16'h1 << B_OVR;

  a_r9_irq_tracks_word: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat_word & IRQ_MASK));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(rx_valid && recv_mode) && !overrun && !dse_event)
    |=> ((stat_word & IRQ_MASK) == 16'h0) && !summary);

  a_r4_no_devend_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !(rx_valid && recv_mode)) |=> $stable(stat_word[B_DEV]));

  a_r6_eot_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_hit && !dse_event)
    |=> summary && ((stat_word & IRQ_MASK & ~OVR_BIT) == DEV_ONLY));

  a_r5_bin_entry_on_escape: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[B_BIN]) |-> $past(ds_hit));

  a_r6_summary_has_devend: assert property (@(posedge clk) disable iff (!rst_n)
    summary |-> stat_word[B_DEV]);
endmodule

bind line_status_word lsw_checker i_lsw_checker (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .recv_mode(recv_mode),
  .overrun(overrun), .stat_rd(stat_rd), .ds_hit(ds_hit), .eot_hit(eot_hit),
  .dse_event(dse_event), .stat_word(stat_word), .summary(summary), .irq(irq)
);

// File: tb/test_line_status_word.sv
module test_line_status_word;
  localparam logic [7:0] DS  = 8'h10;
  localparam logic [7:0] EOT = 8'h04;
  localparam logic [7:0] TXT = 8'h41;
  localparam logic [15:0] RCV = 16'h0400;
  localparam logic [15:0] BIN = 16'h0100;
  localparam logic [15:0] DEV = 16'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recv_mode = 0, xmit_mode = 0, busy = 0, dsr = 0, rx_valid = 0;
  logic [7:0] rx_char = '0;
  logic err_vrc = 0, err_sync = 0, err_lrc = 0, err_nak = 0, overrun = 0, stat_rd = 0;
  logic [15:0] stat_word;
  logic summary, irq;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  line_status_word i_line_status_word (
    .clk(clk), .rst_n(rst_n), .recv_mode(recv_mode), .xmit_mode(xmit_mode),
    .busy(busy), .dsr(dsr), .rx_valid(rx_valid), .rx_char(rx_char),
    .err_vrc(err_vrc), .err_sync(err_sync), .err_lrc(err_lrc), .err_nak(err_nak),
    .overrun(overrun), .stat_rd(stat_rd), .stat_word(stat_word),
    .summary(summary), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [15:0] exp_err(input logic [3:0] m);
    logic [15:0] w;
    w = '0;
    if (m[0] || m[1]) w = w | 16'h0010;
    if (m[2])         w = w | 16'h0008;
    if (m[3])         w = w | 16'h0040;
    if (m != 4'd0)    w = w | 16'h4000;
    return w;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [3:0] m);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = c;
    {err_nak, err_lrc, err_sync, err_vrc} = m;
    @(negedge clk);
    rx_valid = 1'b0;
    {err_nak, err_lrc, err_sync, err_vrc} = 4'd0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic set_recv(input logic v);
    @(negedge clk); recv_mode = v;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] sym [3];
    sym[0] = DS; sym[1] = TXT; sym[2] = EOT;
    repeat (3) @(negedge clk);
    chk("R1 word in reset", stat_word, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", stat_word, 16'h0);
    chk("R1 irq/summary after reset", {14'd0, irq, summary}, 16'h0);

    set_recv(1'b1);
    chk("R7 receive bit", stat_word, RCV);
    @(negedge clk); busy = 1'b1;
    @(negedge clk);
    chk("R7 busy bit", stat_word, RCV | 16'h1000);
    chk("R7 busy no irq", {15'd0, irq}, 16'h0);
    pulse_rd();
    chk("R8 read keeps busy", stat_word, RCV | 16'h1000);
    busy = 1'b0;
    @(negedge clk);

    for (int m = 0; m < 16; m++) begin
      send(TXT, 4'(m));
      chk("R2 R3 error flags", stat_word, RCV | DEV | exp_err(4'(m)));
      chk("R9 irq on request", {15'd0, irq}, 16'h1);
      pulse_rd();
      chk("R8 read clears", stat_word, RCV);
      chk("R9 irq drops", {15'd0, irq}, 16'h0);
    end

    set_recv(1'b0);
    send(TXT, 4'hF);
    chk("R10 char ignored outside receive", stat_word, 16'h0);
    set_recv(1'b1);

    @(negedge clk); overrun = 1'b1;
    @(negedge clk); overrun = 1'b0;
    chk("R4 overrun bit, no device end", stat_word, RCV | 16'h0004);
    pulse_rd();
    @(negedge clk); dsr = 1'b1;
    @(negedge clk); dsr = 1'b0;
    @(negedge clk);
    chk("R4 data set error bit", stat_word, RCV | 16'h0080);
    pulse_rd();

    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        set_recv(1'b0);
        set_recv(1'b1);
        pulse_rd();
        send(sym[a], 4'd0);
        send(sym[b], 4'd0);
        chk("R5 pair binary entry", stat_word,
            RCV | DEV | ((a == 0 && b == 0) ? BIN : 16'h0));
        chk("R6 pair summary", {15'd0, summary},
            {15'd0, (a == 2 || b == 2)});
      end
    end
    pulse_rd();

    set_recv(1'b0);
    set_recv(1'b1);
    send(TXT, 4'b1000);
    send(EOT, 4'b0001);
    chk("R6 eot leaves device end alone", stat_word, RCV | DEV);
    chk("R6 eot summary", {15'd0, summary}, 16'h1);
    pulse_rd();
    chk("R8 summary cleared", {15'd0, summary}, 16'h0);

    send(DS, 4'd0); send(DS, 4'd0);
    chk("R5 binary entered", stat_word, RCV | DEV | BIN);
    pulse_rd();
    chk("R8 read keeps binary", stat_word, RCV | BIN);
    send(TXT, 4'd0);
    chk("R5 data keeps binary", stat_word, RCV | DEV | BIN);
    send(EOT, 4'd0);
    chk("R6 eot is data in binary", {15'd0, summary}, 16'h0);
    chk("R6 binary kept after eot data", stat_word, RCV | DEV | BIN);
    send(DS, 4'd0); send(DS, 4'd0);
    chk("R5 literal escape pair", stat_word, RCV | DEV | BIN);
    send(DS, 4'd0); send(TXT, 4'd0);
    chk("R5 escape then data exits", stat_word, RCV | DEV);
    pulse_rd();

    send(DS, 4'd0); send(DS, 4'd0);
    set_recv(1'b0);
    chk("R5 receive off leaves binary", stat_word & BIN, 16'h0);
    set_recv(1'b1);
    pulse_rd();

    @(negedge clk);
    stat_rd = 1'b1; rx_valid = 1'b1; rx_char = TXT; err_lrc = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0; rx_valid = 1'b0; err_lrc = 1'b0;
    chk("R8 event beats read", stat_word, RCV | DEV | 16'h4008);
    pulse_rd();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule